// File: doc/BRIEF.md
# Burst-Clocked Serial Peripheral Master with Receive Overrun Lockout

This block is a master for a four-wire serial peripheral link (SPI, clock mode 0). A small register bus sets a baud divisor and a control word, and writing the data register starts a transfer. The serial clock is derived from the bus clock by a reloading down-counter. In the normal mode the clock is gated: it produces exactly 8, 16 or 32 pulses per write and then rests low. In the continuous-clock mode it runs freely, and transfers are placed onto the running clock.

Bits shift out on `sdo` most significant first and are taken in from `sdi` at the same time. A finished word is parked in a receive holding register, and software collects it there. If a word finishes while the previous one is still unread, the new word is thrown away and a sticky overflow flag is raised. While that flag stays set, every further completed word is discarded. Only a software write removes the flag.

Top module: `spi_ovr_master`

## Requirements
- R1: The baud divisor N sits in bits [8:0] at address 1 and is 9 bits wide (bits written above bit 8 read back as zero). While the serial clock runs, its period is 2*(N+1) bus clock cycles: N=0 gives 2 cycles and N=511 gives 1024 cycles.
- R2: A write to address 0 while idle starts a transfer of exactly L rising serial clock edges. L is set by the control field at address 2, bits [1:0]: 0 selects 8, 1 selects 16, and 2 or 3 select 32.
- R3: When bit 2 of the control word (continuous clock) is 0, `sck` is low whenever no transfer is in progress.
- R4: When control bit 2 is 1, `sck` toggles every N+1 bus cycles, whether or not a transfer is in progress.
- R5: `sdo` presents bits L-1 down to 0 of the written word, most significant first. Each bit is stable at the rising edge that the far end samples, and it changes only after a falling edge.
- R6: `sdi` is sampled on each rising edge of `sck`, most significant bit first. The completed word reads back from address 0 right-aligned, with the upper bits zero.
- R7: Status bit 0 (at address 3) is 1 from the cycle after the starting write until the final falling `sck` edge of the transfer, and 0 after that.
- R8: Status bit 1 becomes 1 when a completed word is accepted into the holding register. A bus read of address 0 clears it. Looking at the value on `bus_rdata` without asserting `bus_rd` has no side effect.
- R9: Status bit 6 is set when a word completes while status bit 1 is 1 and no read of address 0 happens in that cycle. The completed word is discarded, and address 0 keeps the earlier word.
- R10: While status bit 6 is 1, completed words are discarded and the flag stays set. Only a write to address 3 with data bit 6 equal to 1 clears it. A write there with bit 6 equal to 0 leaves it unchanged.
- R11: If a read of address 0 falls in the same cycle as a word completing, the read returns the old word and the new word is accepted. Status bit 1 stays 1, and no overflow is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only; data is always driven) |
| bus_addr | input | 2 | Register select: 0 data, 1 divisor, 2 control, 3 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
Word completion and software activity on the receive side can land on the same bus clock edge. Two cases matter: a read of the holding register, and a write that clears the overflow flag. The bench provokes the read case by counting from the starting write to the predicted final falling edge, which comes 2*L*(N+1) cycles later, and raising the read strobe for exactly that cycle. It then judges three things: the read must return the older word, the newer word must be resident afterwards with the full flag still set, and the overflow flag must stay clear. The overflow walk checks the other side of the boundary: the same completion without a read must discard the newer word and raise the sticky flag.

// File: rtl/spi_ovr_pkg.sv
package spi_ovr_pkg;

   typedef enum logic [1:0] {
      WL_BYTE  = 2'd0,
      WL_HALF  = 2'd1,
      WL_WORD  = 2'd2,
      WL_WORD2 = 2'd3
   } wlen_e;

   localparam logic [1:0] REG_DATA = 2'd0;
   localparam logic [1:0] REG_BAUD = 2'd1;
   localparam logic [1:0] REG_CTRL = 2'd2;
   localparam logic [1:0] REG_STAT = 2'd3;

   localparam int ST_BUSY = 0;
   localparam int ST_FULL = 1;
   localparam int ST_OVF  = 6;
   localparam int CT_CONT = 2;

   function automatic int unsigned wlen_bits(input wlen_e m);
      case (m)
         WL_BYTE: return 8;
         WL_HALF: return 16;
         default: return 32;
      endcase
   endfunction

endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
   parameter int BRG_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [BRG_W-1:0] div,
   output logic             sck,
   output logic             rise,
   output logic             fall
);

   logic [BRG_W-1:0] cnt_q;
   logic             sck_q;
   logic             tick;

   assign tick = en && (cnt_q == '0);
   assign rise = tick && !sck_q;
   assign fall = tick && sck_q;
   assign sck  = sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sck_q <= 1'b0;
      end else if (!en) begin
         cnt_q <= div;
         sck_q <= 1'b0;
      end else if (tick) begin
         cnt_q <= div;
         sck_q <= ~sck_q;
      end else begin
         cnt_q <= cnt_q - BRG_W'(1);
      end
   end

   AST_SCK_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !tick) |=> $stable(sck_q)); // R1

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
   import spi_ovr_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] tx_word,
   input  wlen_e             mode,
   input  logic              rise,
   input  logic              fall,
   input  logic              sdi,
   output logic              busy,
   output logic              sdo,
   output logic              done,
   output logic [DATA_W-1:0] rx_word
);

   localparam int IDX_W = $clog2(DATA_W);
   localparam int CNT_W = IDX_W + 1;

   logic              busy_q;
   logic [DATA_W-1:0] tx_sr, rx_sr;
   logic [CNT_W-1:0]  bitcnt_q, len_q, msb_idx;
   logic              go;

   assign go      = start && !busy_q;
   assign msb_idx = len_q - CNT_W'(1);
   assign done    = busy_q && fall && (bitcnt_q != '0) && (bitcnt_q == len_q);
   assign busy    = busy_q;
   assign sdo     = busy_q ? tx_sr[msb_idx[IDX_W-1:0]] : 1'b0;
   assign rx_word = rx_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         tx_sr    <= '0;
         rx_sr    <= '0;
         bitcnt_q <= '0;
         len_q    <= '0;
      end else if (go) begin
         busy_q   <= 1'b1;
         tx_sr    <= tx_word;
         rx_sr    <= '0;
         bitcnt_q <= '0;
         len_q    <= CNT_W'(wlen_bits(mode));
      end else if (busy_q) begin
         if (rise) begin
            rx_sr    <= {rx_sr[DATA_W-2:0], sdi};
            bitcnt_q <= bitcnt_q + CNT_W'(1);
         end
         if (fall && (bitcnt_q != '0)) begin
            if (bitcnt_q == len_q) busy_q <= 1'b0;
            else                   tx_sr  <= tx_sr << 1;
         end
      end
   end

   AST_BUSY_UNTIL_LAST_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !done) |=> busy_q); // R7
   AST_BITCNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (bitcnt_q <= len_q)); // R2
   AST_SDO_STEADY_OFF_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !fall) |=> $stable(sdo)); // R5

endmodule

// File: rtl/spi_rx_hold.sv
module spi_rx_hold #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [DATA_W-1:0] word,
   input  logic              rd_take,
   input  logic              ovf_clr,
   output logic [DATA_W-1:0] hold,
   output logic              full,
   output logic              ovf
);

   logic [DATA_W-1:0] hold_q;
   logic              full_q, ovf_q;
   logic              accept;

   assign accept = done && !ovf_q && (!full_q || rd_take);
   assign hold   = hold_q;
   assign full   = full_q;
   assign ovf    = ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         full_q <= 1'b0;
      end else if (accept) begin
         hold_q <= word;
         full_q <= 1'b1;
      end else if (rd_take) begin
         full_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             ovf_q <= 1'b0;
      else if (ovf_q)                         ovf_q <= !ovf_clr;
      else if (done && full_q && !rd_take)    ovf_q <= 1'b1;
   end

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !ovf_clr) |=> ovf_q); // R10
   AST_HOLD_FROZEN_IN_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> $stable(hold_q)); // R10
   AST_OLD_WORD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (done && full_q && !rd_take) |=> $stable(hold_q)); // R9
   AST_READ_MEETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rd_take && !ovf_q) |=> (full_q && !ovf_q)); // R11

endmodule

// File: rtl/spi_ovr_master.sv
module spi_ovr_master
   import spi_ovr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int BRG_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              sck,
   output logic              sdo,
   input  logic              sdi
);

   generate
      if (DATA_W != 32) begin : g_chk_data
         $error("spi_ovr_master: DATA_W must be 32 to hold the widest word");
      end
      if (BRG_W < 1 || BRG_W > 16) begin : g_chk_brg
         $error("spi_ovr_master: BRG_W out of range");
      end
   endgenerate

   logic [BRG_W-1:0]  brg_q;
   logic [1:0]        mode_q;
   logic              cont_q;
   logic              start, rd_take, ovf_clr;
   logic              busy, done, rise, fall;
   logic              full, ovf;
   logic [DATA_W-1:0] rx_word, hold, brg_rd, stat_rd;

   assign start   = bus_wr && (bus_addr == REG_DATA);
   assign rd_take = bus_rd && (bus_addr == REG_DATA);
   assign ovf_clr = bus_wr && (bus_addr == REG_STAT) && bus_wdata[ST_OVF];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brg_q  <= '0;
         mode_q <= 2'd0;
         cont_q <= 1'b0;
      end else if (bus_wr) begin
         if (bus_addr == REG_BAUD) brg_q <= bus_wdata[BRG_W-1:0];
         if (bus_addr == REG_CTRL) begin
            mode_q <= bus_wdata[1:0];
            cont_q <= bus_wdata[CT_CONT];
         end
      end
   end

   spi_baud_gen #(.BRG_W(BRG_W)) u_baud (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (busy || cont_q),
      .div  (brg_q),
      .sck  (sck),
      .rise (rise),
      .fall (fall)
   );

   spi_shift_engine #(.DATA_W(DATA_W)) u_eng (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .tx_word(bus_wdata),
      .mode   (wlen_e'(mode_q)),
      .rise   (rise),
      .fall   (fall),
      .sdi    (sdi),
      .busy   (busy),
      .sdo    (sdo),
      .done   (done),
      .rx_word(rx_word)
   );

   spi_rx_hold #(.DATA_W(DATA_W)) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .done   (done),
      .word   (rx_word),
      .rd_take(rd_take),
      .ovf_clr(ovf_clr),
      .hold   (hold),
      .full   (full),
      .ovf    (ovf)
   );

   generate
      if (BRG_W < DATA_W) begin : g_brg_pad
         assign brg_rd = {{(DATA_W-BRG_W){1'b0}}, brg_q};
      end else begin : g_brg_full
         assign brg_rd = DATA_W'(brg_q);
      end
   endgenerate

   always_comb begin
      stat_rd          = '0;
      stat_rd[ST_BUSY] = busy;
      stat_rd[ST_FULL] = full;
      stat_rd[ST_OVF]  = ovf;
   end

   always_comb begin
      case (bus_addr)
         REG_DATA: bus_rdata = hold;
         REG_BAUD: bus_rdata = brg_rd;
         REG_CTRL: bus_rdata = {{(DATA_W-3){1'b0}}, cont_q, mode_q};
         default:  bus_rdata = stat_rd;
      endcase
   end

   AST_SCK_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cont_q) |=> !sck); // R3
   AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy); // R7

endmodule

// File: tb/sim_spi_ovr_master.sv
module sim_spi_ovr_master;

   localparam int CLK_PERIOD = 10;
   localparam logic [1:0] A_DATA = 2'd0, A_BAUD = 2'd1, A_CTRL = 2'd2, A_STAT = 2'd3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [1:0]  addr = A_STAT;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        sck, sdo;
   logic        sdi = 1'b0;

   int vecs = 0, fails = 0;

   logic [31:0] last_mosi, last_old;
   int          last_rises, last_per;
   bit          last_busy_bad;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_ovr_master u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata), .sck(sck), .sdo(sdo), .sdi(sdi)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk); wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr = 1'b0; addr = A_STAT;
   endtask

   task automatic peek(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk); rd = 1'b0; addr = a; #1 d = rdata;
   endtask

   task automatic take_data(output logic [31:0] d);
      @(negedge clk); rd = 1'b1; addr = A_DATA; #1 d = rdata;
      @(negedge clk); rd = 1'b0; addr = A_STAT;
   endtask

   function automatic logic [31:0] lmask(input int len);
      return (len == 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
   endfunction

   function automatic int mode_len(input int m);
      return (m == 0) ? 8 : (m == 1) ? 16 : 32;
   endfunction

   // Runs one transfer with a bench-side slave that drives sdi and captures sdo.
   task automatic xfer(input int len, input logic [31:0] tx, input logic [31:0] sl, input int rd_at);
      int rises, t1, t2, i;
      bit done_f, bsy;
      logic psck, psdo;
      logic [31:0] sreg;
      sreg = sl; sdi = sreg[len-1];
      last_mosi = '0; rises = 0; t1 = 0; t2 = 0; done_f = 0; last_busy_bad = 0; last_old = '0;
      @(negedge clk); wr = 1'b1; addr = A_DATA; wdata = tx;
      @(negedge clk); wr = 1'b0; addr = A_STAT;
      #1; if (rdata[0] !== 1'b1) last_busy_bad = 1;
      psck = sck; psdo = sdo; i = 1;
      while (!done_f && i < 40000) begin
         @(negedge clk); i++;
         if (rd_at != 0 && i == rd_at) begin rd = 1'b1; addr = A_DATA; end
         else if (rd_at != 0 && i == rd_at + 1) begin rd = 1'b0; addr = A_STAT; end
         if (!psck && sck) begin
            last_mosi = {last_mosi[30:0], psdo};
            rises++;
            if (rises == 1) t1 = i;
            if (rises == 2) t2 = i;
         end
         if (psck && !sck && rises > 0) begin
            if (rises == len) done_f = 1;
            else begin sreg = sreg << 1; sdi = sreg[len-1]; end
         end
         #1;
         if (rd_at != 0 && i == rd_at) last_old = rdata;
         if (addr == A_STAT) begin
            bsy = rdata[0];
            if (!done_f && !bsy) last_busy_bad = 1;
            if (done_f && bsy) last_busy_bad = 1;
         end
         psck = sck; psdo = sdo;
      end
      last_rises = rises;
      last_per = t2 - t1;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end

   initial begin
      logic [31:0] d, s, tx, sl, oldw, neww;
      int len, n, k;
      int nvals[4] = '{0, 1, 3, 6};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // Reset state
      peek(A_STAT, s); chk(s == 32'd0, "R7 reset status", s, 32'd0);
      chk(sck == 1'b0, "R3 reset sck", {31'd0, sck}, 32'd0);
      peek(A_BAUD, d); chk(d == 32'd0, "R1 reset divisor", d, 32'd0);

      // R1: divisor field width
      bus_write(A_BAUD, 32'hFFFF_FFFF);
      peek(A_BAUD, d); chk(d == 32'h1FF, "R1 divisor width", d, 32'h1FF);

      // Sweep of word length and divisor
      for (int m = 0; m < 4; m++) begin
         for (int j = 0; j < 4; j++) begin
            n = nvals[j]; len = mode_len(m);
            tx = 32'hA5C3_1E69 ^ (32'h1111_1111 * m) ^ (32'h0101_0103 * n);
            sl = {tx[12:0], tx[31:13]} ^ 32'h5A5A_F00F;
            bus_write(A_BAUD, n);
            bus_write(A_CTRL, m);
            xfer(len, tx, sl, 0);
            chk(last_rises == len, "R2 pulse count", last_rises, len);
            chk(last_per == 2 * (n + 1), "R1 sck period", last_per, 2 * (n + 1));
            chk(last_mosi == (tx & lmask(len)), "R5 sdo word", last_mosi, tx & lmask(len));
            chk(!last_busy_bad, "R7 busy window", {31'd0, last_busy_bad}, 32'd0);
            peek(A_STAT, s); chk(s == 32'h2, "R8 full after word", s, 32'h2);
            for (int w = 0; w < 2 * (n + 1) + 3; w++) begin
               @(negedge clk);
               if (sck !== 1'b0) chk(1'b0, "R3 sck idle low", {31'd0, sck}, 32'd0);
            end
            chk(sck == 1'b0, "R3 sck idle low", {31'd0, sck}, 32'd0);
            take_data(d); chk(d == (sl & lmask(len)), "R6 received word", d, sl & lmask(len));
            peek(A_STAT, s); chk(s == 32'h0, "R8 full cleared by read", s, 32'h0);
         end
      end

      // Slowest divisor
      bus_write(A_BAUD, 32'd511);
      bus_write(A_CTRL, 32'd0);
      xfer(8, 32'h0000_00C6, 32'h0000_0039, 0);
      chk(last_per == 1024, "R1 slowest period", last_per, 1024);
      chk(last_rises == 8, "R2 pulse count slow", last_rises, 8);
      take_data(d); chk(d == 32'h39, "R6 slow word", d, 32'h39);

      // Overrun walk
      bus_write(A_BAUD, 32'd0);
      xfer(8, 32'h11, 32'h0000_00A1, 0);
      peek(A_STAT, s); chk(s == 32'h2, "R8 first word held", s, 32'h2);
      xfer(8, 32'h22, 32'h0000_00B2, 0);
      peek(A_STAT, s); chk(s == 32'h42, "R9 overflow raised", s, 32'h42);
      peek(A_DATA, d); chk(d == 32'hA1, "R9 old word kept", d, 32'hA1);
      peek(A_STAT, s); chk(s[1] == 1'b1, "R8 peek has no side effect", s, 32'h42);
      xfer(8, 32'h33, 32'h0000_00C3, 0);
      peek(A_DATA, d); chk(d == 32'hA1, "R10 reception locked", d, 32'hA1);
      repeat (50) @(negedge clk);
      peek(A_STAT, s); chk(s == 32'h42, "R10 flag sticky", s, 32'h42);
      bus_write(A_STAT, 32'hFFFF_FFBF);
      peek(A_STAT, s); chk(s == 32'h42, "R10 write without bit6", s, 32'h42);
      bus_write(A_STAT, 32'h0000_0040);
      peek(A_STAT, s); chk(s == 32'h02, "R10 flag cleared", s, 32'h02);
      take_data(d); chk(d == 32'hA1, "R9 old word read", d, 32'hA1);
      xfer(8, 32'h44, 32'h0000_00D4, 0);
      peek(A_STAT, s); chk(s == 32'h02, "R10 reception resumed", s, 32'h02);
      take_data(d); chk(d == 32'hD4, "R10 new word after clear", d, 32'hD4);

      // Same-cycle read and completion
      n = 1; len = 8;
      bus_write(A_BAUD, n);
      xfer(len, 32'h5E, 32'h0000_006B, 0);
      k = 2 * len * (n + 1);
      xfer(len, 32'h7F, 32'h0000_0097, k);
      chk(last_old == 32'h6B, "R11 read returns old word", last_old, 32'h6B);
      peek(A_STAT, s); chk(s == 32'h02, "R11 full kept no overflow", s, 32'h02);
      peek(A_DATA, d); chk(d == 32'h97, "R11 new word accepted", d, 32'h97);
      take_data(d);

      // Continuous clock mode
      bus_write(A_CTRL, 32'h4 | 32'd1);
      xfer(16, 32'h0000_BEEF, 32'h0000_3C5A, 0);
      chk(last_rises == 16, "R4 pulses in continuous mode", last_rises, 16);
      chk(last_mosi == 32'hBEEF, "R5 sdo continuous", last_mosi, 32'hBEEF);
      take_data(d); chk(d == 32'h3C5A, "R6 received continuous", d, 32'h3C5A);
      begin
         int tog; logic p;
         tog = 0;
         @(negedge clk); p = sck;
         for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (sck != p) tog++;
            p = sck;
         end
         chk(tog == 20, "R4 free-running toggles", tog, 20);
      end
      bus_write(A_CTRL, 32'd0);
      repeat (4) @(negedge clk);
      chk(sck == 1'b0, "R3 sck low after leaving continuous", {31'd0, sck}, 32'd0);

      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end

endmodule